// File: doc/BRIEF.md
# PoE Port Power Budget Allocator

This block decides which Power over Ethernet ports may receive power. The total budget is the sum of the programmed capacities of those supplies (up to three) that currently report present. On each evaluation pass the block walks the ports from the most important priority level to the least important. It admits every requesting port whose charge still fits within the budget. The result is published as a per-port enable vector.

A port's charge depends on the accounting mode. In grant mode a port is charged the power of its class: a standard port costs 15.4 W and a high-power port costs 30 W. In measured mode a port is charged the draw reported for it.

Passes repeat on a fixed scan interval without any host involvement. A supply that disappears triggers a pass at once. Ports that no longer fit are shed, and a sticky overload flag is raised. A shed port returns automatically once enough budget comes back.

Top module: `poe_budget_alloc`

## Requirements
- R1: All power values are unsigned integers in units of 0.1 W. In grant mode a port with `port_hipwr`=0 is charged 154 and a port with `port_hipwr`=1 is charged 300.
- R2: In measured mode (`cfg_addr`=3, `cfg_wdata[0]`=1) a port is charged its 16-bit `port_meas` field. Writing `cfg_wdata[0]`=0 to address 3 selects grant mode.
- R3: Ports are considered by 2-bit priority, with 0 as the highest. Within one priority level the lower port index is considered first.
- R4: A requesting port is admitted only if the running total plus its charge is at most the capacity. A port that does not fit is skipped, and the walk still admits later ports that fit. `alloc_total` reports the sum of the charges of the admitted ports.
- R5: Capacity is the sum of the 16-bit capacity registers at `cfg_addr` 0, 1 and 2, counting only those supplies whose `psu_present` bit is set. `cap_total` shows this sum.
- R6: A port whose `port_req` is low is never enabled.
- R7: When any `psu_present` bit falls while no pass is running, `busy` is high in the next cycle. Without a drop, a pass starts every `SCAN_CYCLES` idle cycles.
- R8: `busy` is high for the whole of a pass. `port_en` and `alloc_total` change only in the cycle in which the pass completes, and never while the block is idle.
- R9: `overload` is set at pass completion when a port that was enabled and still requests power is disabled. It stays set until `evt_clr` is pulsed, and a new shed in the same cycle takes precedence over the clear.
- R10: A port that was shed is enabled again on a later pass once the budget covers it.
- R11: After reset `port_en`, `busy`, `overload` and `alloc_total` are 0, all capacities are 0, and grant mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0..2: supply capacity, 3: mode |
| cfg_wdata | input | 16 | Write data |
| evt_clr | input | 1 | Clears the overload flag |
| psu_present | input | 3 | Supply present, one bit per supply |
| port_req | input | NUM_PORTS | Port requests power |
| port_hipwr | input | NUM_PORTS | Port class: 1 = high power |
| port_prio | input | 2*NUM_PORTS | Priority per port, 2 bits each |
| port_meas | input | 16*NUM_PORTS | Measured draw per port, 0.1 W units |
| port_en | output | NUM_PORTS | Port power enable |
| busy | output | 1 | Evaluation pass in progress |
| overload | output | 1 | Sticky shed event |
| alloc_total | output | 18 | Charged total of the enabled ports |
| cap_total | output | 18 | Capacity of the present supplies |

## Verification
The hardest case to reach is a supply drop that arrives while the block is idle. At that moment a full enable vector has to shrink in one atomic step and raise the overload event. The stimulus first fills the budget with all supplies present, waiting for a complete pass. It then removes the largest supply on a falling clock edge while `busy` is low and checks `busy` on the very next cycle. After that it checks the reduced vector, the sticky flag across a further pass, the clear, and re-admission once the supply returns. Skip-and-continue admission and exact-fit boundaries are reached by choosing classes whose charges add up to the capacity exactly.

// File: rtl/poe_alloc_pkg.sv
package poe_alloc_pkg;
    localparam int PWR_W    = 16;
    localparam int CAP_W    = 18;
    localparam int ACC_W    = 19;
    localparam int PRIO_W   = 2;
    localparam int NUM_PRIO = 4;
    localparam int NUM_PSU  = 3;

    localparam logic [PWR_W-1:0] CHARGE_STD = 16'd154;
    localparam logic [PWR_W-1:0] CHARGE_HI  = 16'd300;

    typedef enum logic {
        MODE_GRANT    = 1'b0,
        MODE_MEASURED = 1'b1
    } charge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_COMMIT = 2'd2
    } pass_state_e;

    typedef struct packed {
        logic              req;
        logic              hipwr;
        logic [PRIO_W-1:0] prio;
        logic [PWR_W-1:0]  meas;
    } port_snap_t;

    function automatic logic [PWR_W-1:0] port_charge(port_snap_t p, charge_mode_e m);
        if (m == MODE_MEASURED) return p.meas;
        return p.hipwr ? CHARGE_HI : CHARGE_STD;
    endfunction
endpackage

// File: rtl/poe_cap_regs.sv
module poe_cap_regs
    import poe_alloc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [PWR_W-1:0]    cfg_wdata,
    input  logic [NUM_PSU-1:0]  psu_present,
    output logic [CAP_W-1:0]    cap_total,
    output charge_mode_e        mode
);
    logic [PWR_W-1:0] cap_reg [NUM_PSU];

    for (genvar s = 0; s < NUM_PSU; s++) begin : g_psu
        always_ff @(posedge clk) begin
            if (rst)
                cap_reg[s] <= '0;
            else if (cfg_we && cfg_addr == 2'(s))
                cap_reg[s] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_GRANT;
        else if (cfg_we && cfg_addr == 2'd3)
            mode <= charge_mode_e'(cfg_wdata[0]);
    end

    always_comb begin
        cap_total = '0;
        for (int s = 0; s < NUM_PSU; s++)
            if (psu_present[s])
                cap_total = cap_total + CAP_W'(cap_reg[s]);
    end
endmodule

// File: rtl/poe_pass_seq.sv
module poe_pass_seq
    import poe_alloc_pkg::*;
#(
    parameter int NUM_PORTS   = 8,
    parameter int SCAN_CYCLES = 64,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TMR_W = $clog2(SCAN_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PSU-1:0] psu_present,
    output logic               busy,
    output logic               start,
    output logic               walk,
    output logic               commit,
    output logic [IDX_W-1:0]   port_idx,
    output logic [PRIO_W-1:0]  prio_lvl
);
    pass_state_e        state;
    logic [TMR_W-1:0]   tmr;
    logic [NUM_PSU-1:0] psu_prev;
    logic               drop_pend;
    logic               drop_now;
    logic               last_step;

    assign drop_now  = |(psu_prev & ~psu_present);
    assign busy      = (state != ST_IDLE);
    assign walk      = (state == ST_WALK);
    assign commit    = (state == ST_COMMIT);
    assign start     = (state == ST_IDLE) &&
                       (drop_now || drop_pend || tmr == TMR_W'(SCAN_CYCLES - 1));
    assign last_step = (port_idx == IDX_W'(NUM_PORTS - 1)) &&
                       (prio_lvl == PRIO_W'(NUM_PRIO - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            psu_prev  <= psu_present;
            drop_pend <= 1'b0;
            port_idx  <= '0;
            prio_lvl  <= '0;
        end else begin
            psu_prev <= psu_present;
            if (start)
                drop_pend <= 1'b0;
            else if (drop_now)
                drop_pend <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_WALK;
                        tmr      <= '0;
                        port_idx <= '0;
                        prio_lvl <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_WALK: begin
                    if (last_step) begin
                        state <= ST_COMMIT;
                    end else if (port_idx == IDX_W'(NUM_PORTS - 1)) begin
                        port_idx <= '0;
                        prio_lvl <= prio_lvl + 1'b1;
                    end else begin
                        port_idx <= port_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/poe_admit.sv
module poe_admit
    import poe_alloc_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        walk,
    input  logic                        commit,
    input  logic [IDX_W-1:0]            port_idx,
    input  logic [PRIO_W-1:0]           prio_lvl,
    input  logic [NUM_PORTS-1:0]        port_req,
    input  logic [NUM_PORTS-1:0]        port_hipwr,
    input  logic [PRIO_W*NUM_PORTS-1:0] port_prio,
    input  logic [PWR_W*NUM_PORTS-1:0]  port_meas,
    input  charge_mode_e                mode,
    input  logic [CAP_W-1:0]            cap_total,
    output logic [NUM_PORTS-1:0]        port_en,
    output logic [CAP_W-1:0]            alloc_total,
    output logic                        shed_now,
    output logic [CAP_W-1:0]            snap_cap,
    output logic [NUM_PORTS-1:0]        snap_req
);
    port_snap_t   live [NUM_PORTS];
    port_snap_t   snap [NUM_PORTS];
    charge_mode_e snap_mode;
    logic [NUM_PORTS-1:0] shadow;
    logic [CAP_W-1:0]     running;

    port_snap_t       cur;
    logic [PWR_W-1:0] chg;
    logic [ACC_W-1:0] trial;
    logic             fits;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign live[i].req   = port_req[i];
        assign live[i].hipwr = port_hipwr[i];
        assign live[i].prio  = port_prio[i*PRIO_W +: PRIO_W];
        assign live[i].meas  = port_meas[i*PWR_W +: PWR_W];
        assign snap_req[i]   = snap[i].req;
    end

    always_comb begin
        cur   = snap[port_idx];
        chg   = port_charge(cur, snap_mode);
        trial = ACC_W'(running) + ACC_W'(chg);
        fits  = cur.req && (cur.prio == prio_lvl) && (trial <= ACC_W'(snap_cap));
    end

    assign shed_now = commit && |(port_en & ~shadow & snap_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PORTS; i++) snap[i] <= '0;
            snap_mode   <= MODE_GRANT;
            snap_cap    <= '0;
            shadow      <= '0;
            running     <= '0;
            port_en     <= '0;
            alloc_total <= '0;
        end else if (start) begin
            for (int i = 0; i < NUM_PORTS; i++) snap[i] <= live[i];
            snap_mode <= mode;
            snap_cap  <= cap_total;
            shadow    <= '0;
            running   <= '0;
        end else if (walk) begin
            if (fits) begin
                shadow[port_idx] <= 1'b1;
                running          <= trial[CAP_W-1:0];
            end
        end else if (commit) begin
            port_en     <= shadow;
            alloc_total <= running;
        end
    end
endmodule

// File: rtl/poe_budget_alloc.sv
module poe_budget_alloc
    import poe_alloc_pkg::*;
#(
    parameter int NUM_PORTS   = 8,
    parameter int SCAN_CYCLES = 64,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_addr,
    input  logic [15:0]                 cfg_wdata,
    input  logic                        evt_clr,
    input  logic [2:0]                  psu_present,
    input  logic [NUM_PORTS-1:0]        port_req,
    input  logic [NUM_PORTS-1:0]        port_hipwr,
    input  logic [2*NUM_PORTS-1:0]      port_prio,
    input  logic [16*NUM_PORTS-1:0]     port_meas,
    output logic [NUM_PORTS-1:0]        port_en,
    output logic                        busy,
    output logic                        overload,
    output logic [17:0]                 alloc_total,
    output logic [17:0]                 cap_total
);
    charge_mode_e         mode;
    logic                 start, walk, commit, shed_now;
    logic [IDX_W-1:0]     port_idx;
    logic [PRIO_W-1:0]    prio_lvl;
    logic [CAP_W-1:0]     snap_cap;
    logic [NUM_PORTS-1:0] snap_req;

    poe_cap_regs cap_i (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .psu_present,
        .cap_total, .mode
    );

    poe_pass_seq #(.NUM_PORTS(NUM_PORTS), .SCAN_CYCLES(SCAN_CYCLES)) seq_i (
        .clk, .rst, .psu_present, .busy, .start, .walk, .commit,
        .port_idx, .prio_lvl
    );

    poe_admit #(.NUM_PORTS(NUM_PORTS)) adm_i (
        .clk, .rst, .start, .walk, .commit, .port_idx, .prio_lvl,
        .port_req, .port_hipwr, .port_prio, .port_meas, .mode, .cap_total,
        .port_en, .alloc_total, .shed_now, .snap_cap, .snap_req
    );

    always_ff @(posedge clk) begin
        if (rst)
            overload <= 1'b0;
        else if (shed_now)
            overload <= 1'b1;
        else if (evt_clr)
            overload <= 1'b0;
    end
endmodule

// File: rtl/poe_budget_alloc_chk.sv
module poe_budget_alloc_chk #(
    parameter int NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 overload,
    input logic                 evt_clr,
    input logic [2:0]           psu_present,
    input logic [NUM_PORTS-1:0] port_en,
    input logic [17:0]          alloc_total,
    input logic [17:0]          snap_cap,
    input logic [NUM_PORTS-1:0] snap_req
);
    // R8
    en_update_at_pass_end_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_en) |-> $past(busy));

    // R8
    total_update_at_pass_end_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(alloc_total) |-> $past(busy));

    // R4
    within_budget_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (alloc_total <= snap_cap));

    // R6
    only_requesting_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ((port_en & ~snap_req) == '0));

    // R9
    overload_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overload && !evt_clr) |=> overload);

    // R7
    drop_starts_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && |($past(psu_present) & ~psu_present)) |=> busy);
endmodule

bind poe_budget_alloc poe_budget_alloc_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .overload(overload), .evt_clr(evt_clr),
    .psu_present(psu_present), .port_en(port_en), .alloc_total(alloc_total),
    .snap_cap(snap_cap), .snap_req(snap_req)
);

// File: tb/poe_budget_alloc_tb.sv
module poe_budget_alloc_tb_top;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          evt_clr = 1'b0;
    logic [2:0]    psu_present = '0;
    logic [N-1:0]  port_req = '0;
    logic [N-1:0]  port_hipwr = '0;
    logic [2*N-1:0]  port_prio = '0;
    logic [16*N-1:0] port_meas = '0;
    logic [N-1:0]  port_en;
    logic          busy, overload;
    logic [17:0]   alloc_total, cap_total;

    int n_run = 0;
    int n_fail = 0;
    int cap_val [3] = '{600, 300, 154};
    logic meas_mode = 1'b0;

    always #10 clk = ~clk;

    poe_budget_alloc #(.NUM_PORTS(N), .SCAN_CYCLES(64)) dut_i (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .evt_clr, .psu_present,
        .port_req, .port_hipwr, .port_prio, .port_meas,
        .port_en, .busy, .overload, .alloc_total, .cap_total
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_cap();
        int c = 0;
        for (int s = 0; s < 3; s++) if (psu_present[s]) c += cap_val[s];
        return c;
    endfunction

    function automatic int charge_of(int i);
        if (meas_mode) return int'(port_meas[i*16 +: 16]);
        return port_hipwr[i] ? 300 : 154;
    endfunction

    // Requirement model: priority walk, skip what does not fit
    task automatic model(output logic [N-1:0] en, output int tot);
        int cap = exp_cap();
        en = '0; tot = 0;
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < N; i++)
                if (port_req[i] && int'(port_prio[2*i +: 2]) == p &&
                    tot + charge_of(i) <= cap) begin
                    en[i] = 1'b1;
                    tot += charge_of(i);
                end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_pass();
        @(negedge clk);
        while (busy) @(negedge clk);
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        while (busy) @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic check_model(input string tag);
        logic [N-1:0] en; int tot;
        model(en, tot);
        check(port_en == en, {tag, " enable"}, port_en, en);
        check(alloc_total == 18'(tot), {tag, " total"}, alloc_total, tot);
    endtask

    task automatic t_reset();
        check(port_en == '0, "R11 port_en", port_en, 0);
        check(!busy, "R11 busy", busy, 0);
        check(!overload, "R11 overload", overload, 0);
        check(alloc_total == '0, "R11 alloc_total", alloc_total, 0);
        psu_present = 3'b111;
        @(negedge clk);
        check(cap_total == '0, "R11 capacities", cap_total, 0);
    endtask

    task automatic t_program();
        for (int s = 0; s < 3; s++) cfg_write(2'(s), 16'(cap_val[s]));
        @(negedge clk);
        check(cap_total == 18'd1054, "R5 all present", cap_total, 1054);
        psu_present = 3'b101;
        @(negedge clk);
        check(cap_total == 18'd754, "R5 subset", cap_total, 754);
    endtask

    task automatic t_grant_mix();
        psu_present = 3'b111;
        port_req = 8'hFF; port_hipwr = 8'b1011_0101;
        port_prio = {2'd3, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd3};
        run_pass();
        check_model("R1 R3 grant mix");
    endtask

    task automatic t_tie();
        psu_present = 3'b010;
        port_req = 8'hFF; port_hipwr = 8'hFF; port_prio = {N{2'd2}};
        run_pass();
        check(port_en == 8'h01, "R3 tie lower index", port_en, 8'h01);
        check(alloc_total == 18'd300, "R1 high class charge", alloc_total, 300);
    endtask

    task automatic t_exact_fit();
        psu_present = 3'b110;
        port_req = 8'h03; port_hipwr = 8'h01; port_prio = '0;
        run_pass();
        check(port_en == 8'h03, "R4 exact fit", port_en, 8'h03);
        check(alloc_total == 18'd454, "R1 R4 total", alloc_total, 454);
    endtask

    task automatic t_skip();
        port_req = 8'h07; port_hipwr = 8'h03; port_prio = '0;
        run_pass();
        check(port_en == 8'h05, "R4 skip and continue", port_en, 8'h05);
    endtask

    task automatic t_no_req();
        psu_present = 3'b111;
        port_req = 8'hFE; port_hipwr = '0; port_prio = '0;
        run_pass();
        check(port_en[0] == 1'b0, "R6 idle request", port_en[0], 0);
        check_model("R6 others");
    endtask

    task automatic t_measured();
        cfg_write(2'd3, 16'd1);
        meas_mode = 1'b1;
        psu_present = 3'b010;
        port_req = 8'hFF; port_hipwr = 8'hFF; port_prio = '0;
        for (int i = 0; i < N; i++) port_meas[i*16 +: 16] = 16'd50;
        port_meas[15:0] = 16'd120; port_meas[31:16] = 16'd200; port_meas[47:32] = 16'd80;
        run_pass();
        check(port_en == 8'h1D, "R2 measured enable", port_en, 8'h1D);
        check(alloc_total == 18'd300, "R2 measured total", alloc_total, 300);
        cfg_write(2'd3, 16'd0);
        meas_mode = 1'b0;
    endtask

    task automatic t_drop_shed();
        logic [N-1:0] held;
        psu_present = 3'b111;
        port_req = 8'hFF; port_hipwr = '0; port_prio = '0;
        run_pass();
        pulse_clr();
        check(port_en == 8'h3F && !overload, "R4 full budget", {overload, port_en}, 8'h3F);
        @(negedge clk);
        while (busy) @(negedge clk);
        held = port_en;
        psu_present = 3'b110;
        @(negedge clk);
        check(busy, "R7 drop starts pass", busy, 1);
        @(negedge clk);
        check(port_en == held, "R8 enable held mid pass", port_en, held);
        while (busy) @(negedge clk);
        check(port_en == 8'h03, "R9 shed vector", port_en, 8'h03);
        check(overload, "R9 overload set", overload, 1);
    endtask

    task automatic t_sticky();
        run_pass();
        check(overload, "R9 overload sticky", overload, 1);
        pulse_clr();
        @(negedge clk);
        check(!overload, "R9 overload cleared", overload, 0);
    endtask

    task automatic t_readmit();
        psu_present = 3'b111;
        run_pass();
        check(port_en == 8'h3F, "R10 readmitted", port_en, 8'h3F);
        check(!overload, "R9 no shed no flag", overload, 0);
    endtask

    task automatic t_periodic();
        int gap = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        while (!busy) begin @(negedge clk); gap++; end
        while (busy) @(negedge clk);
        gap = 0;
        while (!busy) begin @(negedge clk); gap++; end
        check(gap == 64, "R7 scan period", gap, 64);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_grant_mix();
        t_tie();
        t_exact_fit();
        t_skip();
        t_no_req();
        t_measured();
        t_drop_shed();
        t_sticky();
        t_readmit();
        t_periodic();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule